// File: doc/BRIEF.md
# Burst-of-Four Separate-Port SRAM

This block is a synchronous memory with an independent read port and write port that share one command address. Each accepted command moves a fixed burst of four data words. The whole block runs on a single double-rate beat clock `clk`. Every second rising edge of `clk` stands for a rising edge of the main clock. The other edges stand for rising edges of the inverted main clock. The output `cmd_slot` is high during the half-period that ends on a main edge. Read-select, write-select and address are sampled only on those edges.

The block keeps the type of the command it loaded at the previous main edge. A read directly after a read is dropped, and so is a write directly after a write. A burst already running on one port therefore cannot be cut short or restarted by a new command. Alternating reads and writes keep both ports busy at full rate. The burst generates the two low word-index bits itself. The external address selects a group of four words. Each word has two byte lanes, and each lane has its own active-low write enable that is sampled together with that beat's data.

Read data leaves the block as a stream qualified by `q_valid`. The beats have fixed timing, so there is no ready input and the consumer has no means to apply back-pressure. It must take every beat on the edge where `q_valid` is high. While no read beat is being driven, the data bus is zero and `q_valid` is low. This stands in for a high-impedance bus.

Top module: `quad_burst_sram`

## Requirements
- R1: While reset is low and directly after it, `q_valid` is 0, `q` is 0 and every stored word reads back as 0. The previous-command state starts as deselect, so the first command may be a read or a write.
- R2: `cmd_slot` is high on the first edge after reset and then alternates on every `clk` edge. `rd_n`, `wr_n` and `addr` have no effect on edges where `cmd_slot` was low.
- R3: A read command (`rd_n` low) is ignored when the command loaded at the previous main edge was a read.
- R4: A write command (`wr_n` low, `rd_n` high) is ignored when the command loaded at the previous main edge was a write.
- R5: When both selects are low, a read is taken unless the previous command was a read; in that case a write is taken. At most one command is loaded per main edge.
- R6: With both selects high the block is deselected: no burst starts and memory is unchanged.
- R7: Each burst covers word indices {addr, 0}, {addr, 1}, {addr, 2} and {addr, 3}, in that order. The low two bits are generated internally.
- R8: For a write loaded at `clk` edge t, beat k (k = 0..3) of `wdata`/`wbe_n` is captured at edge t+2+k. A read whose beat is launched at a later edge returns the new data.
- R9: For a read loaded at edge t, beat k appears on `q` with `q_valid` high after edge t+2+k. Its value is the stored word as it stood before that edge.
- R10: `wbe_n[0]` guards bits 8:0 and `wbe_n[1]` guards bits 17:9. A lane whose enable is high on a beat keeps its stored value. All enables high on all beats leave the words unchanged.
- R11: When no read beat is being driven, `q_valid` is 0 and `q` is 0, including the cycle after a deselect or write that did not follow a read.
- R12: A running burst always completes its four beats. Alternating read and write commands keep both ports streaming without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate beat clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_slot | output | 1 | High when the next edge is a main-clock edge |
| rd_n | input | 1 | Read select, active low |
| wr_n | input | 1 | Write select, active low |
| addr | input | ADDR_W | Burst address (word index without its two low bits) |
| wdata | input | LANES*LANE_W | Write data beat |
| wbe_n | input | LANES | Per-lane write enables, active low, one per beat |
| q | output | LANES*LANE_W | Read data beat, zero when idle |
| q_valid | output | 1 | High while a read beat is on `q` |

## Verification
The hardest state to reach is the one where both selects are low and the outcome depends on the command loaded one main edge earlier. The same pattern can then yield a read, a write, or nothing. Directed sequences walk this rule through each previous-command state. The stimulus also places a read right after a write to the same address, which makes the read and write bursts overlap by two beats. Random stimulus with a high select rate produces long runs of alternating and ignored commands. On the edges that are not command edges it drives noise on the command pins and unused data slots, and the bench model predicts every beat from the timing rules alone.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/qb4_cmd_ctrl.sv
module qb4_cmd_ctrl
  import qb4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic kslot,
  output logic rd_acc,
  output logic wr_acc
);
  logic ph;
  op_e  prev;

  assign kslot = ~ph;

  // Command gating by the type loaded at the previous main edge
  always_comb begin
    rd_acc = rst_n && kslot && !rd_n && (prev != OP_RD);
    wr_acc = rst_n && kslot && !wr_n && (prev != OP_WR) && !rd_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      prev <= OP_NONE;
    end else begin
      ph <= ~ph;
      if (kslot) prev <= rd_acc ? OP_RD : (wr_acc ? OP_WR : OP_NONE);
    end
  end

  p_slot_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kslot |=> !kslot);
  p_no_rd_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> !$past(rd_acc, 2));
  p_no_wr_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> !$past(wr_acc, 2));
  p_one_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_acc, wr_acc}));
endmodule

// File: rtl/qb4_burst_seq.sv
module qb4_burst_seq #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kslot,
  input  logic          load,
  input  logic [AW-1:0] addr,
  output logic          act_v,
  output logic [AW+1:0] idx
);
  localparam logic [1:0] LAST_BEAT = 2'd3;

  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [AW-1:0] act_a;
  logic [1:0]    beat;

  assign idx = {act_a, beat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      act_v  <= 1'b0;
      act_a  <= '0;
      beat   <= '0;
    end else begin
      if (kslot) begin
        pend_v <= load;
        if (load) pend_a <= addr;
      end
      // A new burst only takes over on a phase edge after the last beat
      if (!kslot && (!act_v || beat == LAST_BEAT)) begin
        act_v <= pend_v;
        act_a <= pend_a;
        beat  <= '0;
      end else if (act_v) begin
        beat <= beat + 2'd1;
      end
    end
  end

  p_burst_whole_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v && beat != LAST_BEAT) |=> (act_v && beat == $past(beat) + 2'd1));
  p_last_beat_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v && beat == LAST_BEAT) |-> !kslot);
endmodule

// File: rtl/qb4_array.sv
module qb4_array #(
  parameter int AW     = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW+1:0]           widx,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wbe_n,
  input  logic                    re,
  input  logic [AW+1:0]           ridx,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_valid
);
  localparam int IW    = AW + 2;
  localparam int DEPTH = 1 << IW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_l;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        q_l <= '0;
      end else begin
        if (we && !wbe_n[l]) mem[widx] <= wdata[l*LANE_W +: LANE_W];
        q_l <= re ? mem[ridx] : '0;
      end
    end

    assign q[l*LANE_W +: LANE_W] = q_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= re;
  end

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> (q == '0));
endmodule

// File: rtl/quad_burst_sram.sv
module quad_burst_sram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    cmd_slot,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wbe_n,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_valid
);
  localparam int IW = ADDR_W + 2;

  logic          kslot, rd_acc, wr_acc;
  logic          rd_act, wr_act;
  logic [IW-1:0] rd_idx, wr_idx;

  assign cmd_slot = kslot;

  qb4_cmd_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .kslot  (kslot),
    .rd_acc (rd_acc),
    .wr_acc (wr_acc)
  );

  qb4_burst_seq #(.AW(ADDR_W)) u_rd_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .kslot (kslot),
    .load  (rd_acc),
    .addr  (addr),
    .act_v (rd_act),
    .idx   (rd_idx)
  );

  qb4_burst_seq #(.AW(ADDR_W)) u_wr_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .kslot (kslot),
    .load  (wr_acc),
    .addr  (addr),
    .act_v (wr_act),
    .idx   (wr_idx)
  );

  qb4_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_act),
    .widx    (wr_idx),
    .wdata   (wdata),
    .wbe_n   (wbe_n),
    .re      (rd_act),
    .ridx    (rd_idx),
    .q       (q),
    .q_valid (q_valid)
  );

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc, 3) |-> q_valid);
  p_wr_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_acc, 2) |-> wr_act);
endmodule

// File: tb/quad_burst_sram_tb.sv
`timescale 1ns/1ps
module quad_burst_sram_tb;
  localparam int AW = 4;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_slot, rd_n, wr_n, q_valid;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, q;
  logic [1:0] wbe_n;

  always #5 clk = ~clk;

  quad_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_slot(cmd_slot), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .wbe_n(wbe_n), .q(q), .q_valid(q_valid)
  );

  logic [DW-1:0] refm [64];
  bit            rs_v [8];
  logic [5:0]    rs_i [8];
  bit            ws_v [8];
  logic [5:0]    ws_i [8];
  logic [DW-1:0] ws_d [8];
  logic [1:0]    ws_b [8];
  int    prev_op = 0;
  int    e = 0;
  int    be_mode = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R9";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", tag, act, exp, e);
    end
  endtask

  task automatic one_edge(input bit is_main, input bit r, input bit w, input logic [AW-1:0] a);
    int s;
    logic [DW-1:0] exp_q;
    bit exp_v;
    s = e % 8;
    chk(cmd_slot === is_main, "R2 slot", {31'd0, cmd_slot}, {31'd0, is_main});
    if (is_main) begin
      rd_n = r; wr_n = w; addr = a;
    end else begin
      rd_n = 1'($urandom); wr_n = 1'($urandom); addr = AW'($urandom);
    end
    if (ws_v[s]) begin
      wdata = ws_d[s]; wbe_n = ws_b[s];
    end else begin
      wdata = DW'($urandom); wbe_n = 2'($urandom);
    end
    @(posedge clk); #1;
    exp_v = rs_v[s];
    exp_q = rs_v[s] ? refm[rs_i[s]] : '0;
    chk(q_valid === exp_v, $sformatf("R11/%s valid", cur_tag), {31'd0, q_valid}, {31'd0, exp_v});
    chk(q === exp_q, $sformatf("%s data", cur_tag), {14'd0, q}, {14'd0, exp_q});
    rs_v[s] = 1'b0;
    if (ws_v[s]) begin
      if (!ws_b[s][0]) refm[ws_i[s]][8:0]  = ws_d[s][8:0];
      if (!ws_b[s][1]) refm[ws_i[s]][17:9] = ws_d[s][17:9];
      ws_v[s] = 1'b0;
    end
    if (is_main) begin
      if (!r && prev_op != 1) begin
        for (int k = 0; k < 4; k++) begin
          rs_v[(e+2+k)%8] = 1'b1;
          rs_i[(e+2+k)%8] = {a, 2'(k)};
        end
        prev_op = 1;
      end else if (!w && prev_op != 2) begin
        for (int k = 0; k < 4; k++) begin
          ws_v[(e+2+k)%8] = 1'b1;
          ws_i[(e+2+k)%8] = {a, 2'(k)};
          ws_d[(e+2+k)%8] = DW'($urandom);
          ws_b[(e+2+k)%8] = (be_mode == 1) ? 2'b11 : 2'($urandom);
        end
        prev_op = 2;
      end else begin
        prev_op = 0;
      end
    end
    e++;
  endtask

  task automatic main_cyc(input bit r, input bit w, input logic [AW-1:0] a);
    one_edge(1'b1, r, w, a);
    one_edge(1'b0, 1'b1, 1'b1, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) main_cyc(1'b1, 1'b1, '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) refm[i] = '0;
    for (int i = 0; i < 8; i++) begin rs_v[i] = 0; ws_v[i] = 0; end
    rd_n = 1'b1; wr_n = 1'b1; addr = '0; wdata = '0; wbe_n = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    chk(q_valid === 1'b0, "R1 reset valid", {31'd0, q_valid}, 32'd0);
    chk(q === '0, "R1 reset data", {14'd0, q}, 32'd0);
    rst_n = 1'b1;

    cur_tag = "R1";  main_cyc(0, 1, 4'd5); idle(2);
    cur_tag = "R3";  main_cyc(1, 0, 4'd2); idle(2);
                     main_cyc(0, 1, 4'd2); main_cyc(0, 1, 4'd3); idle(3);
    cur_tag = "R4";  main_cyc(1, 0, 4'd7); main_cyc(1, 0, 4'd8); idle(2);
                     main_cyc(0, 1, 4'd8); idle(3);
    cur_tag = "R5";  main_cyc(1, 0, 4'd1); main_cyc(0, 0, 4'd1);
                     main_cyc(0, 0, 4'd4); main_cyc(0, 0, 4'd4); idle(3);
    cur_tag = "R6";  idle(3); main_cyc(0, 1, 4'd4); idle(3);
    cur_tag = "R10"; be_mode = 1; main_cyc(1, 0, 4'd2); idle(2); be_mode = 0;
                     main_cyc(0, 1, 4'd2); idle(1); main_cyc(1, 0, 4'd2); idle(2);
                     main_cyc(0, 1, 4'd2); idle(3);
    cur_tag = "R8";  main_cyc(1, 0, 4'd9); main_cyc(0, 1, 4'd9); idle(3);
    cur_tag = "R7";  main_cyc(0, 1, 4'd15); idle(3);
    cur_tag = "R12";
    for (int i = 0; i < 20; i++) main_cyc(i[0], !i[0], AW'($urandom));
    idle(3);
    cur_tag = "R9";
    for (int i = 0; i < 600; i++)
      main_cyc(($urandom % 3) == 0, ($urandom % 3) == 0, AW'($urandom));
    idle(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule